// File: doc/BRIEF.md
# Real-Time Clock with Guarded Register Access

This block keeps time as a 12-bit fraction-of-a-second count and a 32-bit whole-second count, both advanced by a single-cycle tick enable that arrives already in the clock domain. It carries two alarms. A time-of-day alarm compares the low 20 bits of the seconds count against a programmed value. A fractional alarm is a reloading down-counter that fires at a fixed number of ticks. Each alarm raises a sticky flag that software clears by writing a one to it.

Software reaches everything through a small synchronous register bus: select, write strobe, 3-bit address, 32-bit write data, and combinational read data. The address map is: 0 seconds, 1 sub-seconds, 2 time-of-day alarm (20 bits), 3 sub-second alarm reload (12 bits), 4 oscillator trim (8 bits, storage only), 5 control, 6 alarm flags. In the control word, bit 0 is busy (read-only), bit 1 is ready (read-only), bit 2 is counter write permission, bit 3 enables the time-of-day alarm and bit 4 enables the sub-second alarm. In the flags word, bit 0 is the time-of-day flag and bit 1 is the sub-second flag.

Each writable register has its own admission rule. Any write that breaks its rule is dropped silently. After an accepted write, a short busy window blocks further writes. Ready drops in any cycle in which the counters advance, and a counter read in that cycle is marked stale.

Top module: `rtc_guarded`

## Requirements
- R1: Each tick increments the 12-bit sub-seconds count. When it passes 4095 it returns to 0 and the 32-bit seconds count increments by one.
- R2: Control bit 1 (ready) is 0 in every cycle in which tick_en is high and 1 otherwise. A read of address 0 or 1 in such a cycle drives rd_stale high.
- R3: Control bit 0 (busy) is 1 for exactly two cycles after any accepted write. Every write presented in those cycles is dropped.
- R4: Writes to addresses 0, 1 and 4 take effect only when busy is 0 and control bit 2 is 1. Otherwise the register keeps its value.
- R5: A write to address 2 takes effect only when busy is 0 and control bit 3 is 0.
- R6: A write to address 3 takes effect only when busy is 0 and control bit 4 is 0.
- R7: A write to address 5 takes effect when busy is 0. It loads control bits 4:2 from write-data bits 4:2.
- R8: The time-of-day flag (tod_alarm, flags bit 0) sets when the seconds count steps to a value whose low 20 bits equal the alarm while control bit 3 is 1. It stays set until a write to address 6 with bit 0 = 1. A set in the same cycle wins over a clear.
- R9: While control bit 4 is 1, the sub-second alarm sets its sticky flag (sub_alarm, flags bit 1) on every N-th tick, where N is the reload value (0 acts as 1), and reloads. While the bit is 0, the down-counter holds the reload value. Writing 1 to flags bit 1 clears the flag.
- R10: If an accepted write to address 0 or 1 coincides with a tick, the written value is loaded and that tick does not advance either counter.
- R11: After reset, all registers, flags and busy are 0. Reads of unmapped address 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable pulse, synchronous to clk |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rd_stale | output | 1 | Counter read coincides with a counter update |
| tod_alarm | output | 1 | Sticky time-of-day alarm flag |
| sub_alarm | output | 1 | Sticky sub-second alarm flag |

## Verification
The assertions assume that tick_en and every bus input are stable across the sampling edge and are already synchronous to clk. They also assume that a bus access lasts a single cycle, so that a held write strobe counts as one new write per cycle. The stimulus drives every input one time unit after a falling edge and holds it for whole cycles. It issues single-cycle strobes only. It deliberately places writes inside busy windows, against closed enable bits, and in the same cycle as a tick, so that the admission rules are exercised within those assumptions.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        A_SEC    = 3'd0,
        A_SUB    = 3'd1,
        A_TOD    = 3'd2,
        A_SALM   = 3'd3,
        A_OSC    = 3'd4,
        A_CTRL   = 3'd5,
        A_FLAG   = 3'd6
    } rtc_addr_e;

    localparam int CB_BUSY   = 0;
    localparam int CB_READY  = 1;
    localparam int CB_WEN    = 2;
    localparam int CB_TOD_EN = 3;
    localparam int CB_SUB_EN = 4;

    localparam int FB_TOD = 0;
    localparam int FB_SUB = 1;

endpackage

// File: rtl/rtc_access_guard.sv
module rtc_access_guard
    import rtc_pkg::*;
#(
    parameter int BUSY_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  logic [2:0] addr,
    input  logic       wen,
    input  logic       tod_en,
    input  logic       sub_en,
    output logic       busy,
    output logic       ok_sec,
    output logic       ok_sub,
    output logic       ok_tod,
    output logic       ok_salm,
    output logic       ok_osc,
    output logic       ok_ctrl
);

    localparam int BW = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        logic [BW-1:0] cnt;
    } guard_t;

    guard_t q, d;
    logic   free;
    logic   accepted;

    always_comb begin
        d        = q;
        busy     = (q.cnt != '0);
        free     = wr_req && !busy;
        ok_sec   = free && (addr == A_SEC)  && wen;
        ok_sub   = free && (addr == A_SUB)  && wen;
        ok_osc   = free && (addr == A_OSC)  && wen;
        ok_tod   = free && (addr == A_TOD)  && !tod_en;
        ok_salm  = free && (addr == A_SALM) && !sub_en;
        ok_ctrl  = free && (addr == A_CTRL);
        accepted = ok_sec || ok_sub || ok_osc || ok_tod || ok_salm || ok_ctrl;
        if (accepted) begin
            d.cnt = BW'(BUSY_CYC);
        end else if (busy) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> busy); // R3

    AST_BUSY_SINGLE_ADMIT: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> !accepted); // R3

endmodule

// File: rtl/rtc_time_count.sv
module rtc_time_count #(
    parameter int SUB_W = 12,
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld_sec,
    input  logic             ld_sub,
    input  logic [SEC_W-1:0] wdata,
    output logic [SEC_W-1:0] sec,
    output logic [SUB_W-1:0] sub,
    output logic             sec_step,
    output logic [SEC_W-1:0] sec_nxt
);

    localparam logic [SUB_W-1:0] SUB_MAX = '1;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d        = q;
        sec_step = 1'b0;
        if (ld_sec) d.sec = wdata;
        if (ld_sub) d.sub = wdata[SUB_W-1:0];
        if (tick && !ld_sec && !ld_sub) begin
            if (q.sub == SUB_MAX) begin
                d.sub    = '0;
                d.sec    = q.sec + 1'b1;
                sec_step = 1'b1;
            end else begin
                d.sub = q.sub + 1'b1;
            end
        end
        sec_nxt = d.sec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sec = q.sec;
    assign sub = q.sub;

    AST_SUB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_sec && !ld_sub && sub == SUB_MAX)
        |=> (sub == '0) && (sec == SEC_W'($past(sec) + 1'b1))); // R1

    AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ld_sub && !ld_sec) |=> (sub == $past(wdata[SUB_W-1:0])) && $stable(sec)); // R10

endmodule

// File: rtl/rtc_sub_alarm.sv
module rtc_sub_alarm #(
    parameter int SUB_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [SUB_W-1:0] reload,
    output logic             hit
);

    typedef struct packed {
        logic [SUB_W-1:0] cnt;
    } dn_t;

    dn_t q, d;

    always_comb begin
        d   = q;
        hit = 1'b0;
        if (!en) begin
            d.cnt = reload;
        end else if (tick) begin
            if (q.cnt <= SUB_W'(1)) begin
                hit   = 1'b1;
                d.cnt = reload;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && q.cnt > SUB_W'(1)) |=> (q.cnt == $past(q.cnt) - 1'b1)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(q.cnt) || !$past(en)); // R9

endmodule

// File: rtl/rtc_guarded.sv
module rtc_guarded
    import rtc_pkg::*;
#(
    parameter int SUB_W    = 12,
    parameter int SEC_W    = 32,
    parameter int TOD_W    = 20,
    parameter int OSC_W    = 8,
    parameter int BUSY_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [SEC_W-1:0] bus_wdata,
    output logic [SEC_W-1:0] bus_rdata,
    output logic             rd_stale,
    output logic             tod_alarm,
    output logic             sub_alarm
);

    typedef struct packed {
        logic [TOD_W-1:0] tod;
        logic [SUB_W-1:0] salm;
        logic [OSC_W-1:0] osc;
        logic             wen;
        logic             tod_en;
        logic             sub_en;
        logic             tod_flag;
        logic             sub_flag;
    } regs_t;

    regs_t q, d;

    logic             wr_req;
    logic             busy;
    logic             ok_sec, ok_sub, ok_tod, ok_salm, ok_osc, ok_ctrl;
    logic [SEC_W-1:0] sec;
    logic [SUB_W-1:0] sub;
    logic             sec_step;
    logic [SEC_W-1:0] sec_nxt;
    logic             sub_hit;
    logic             tod_set;
    logic [1:0]       clr;
    logic             ready;

    assign wr_req = bus_sel && bus_wr;
    assign ready  = !tick_en;

    rtc_access_guard #(.BUSY_CYC(BUSY_CYC)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .addr    (bus_addr),
        .wen     (q.wen),
        .tod_en  (q.tod_en),
        .sub_en  (q.sub_en),
        .busy    (busy),
        .ok_sec  (ok_sec),
        .ok_sub  (ok_sub),
        .ok_tod  (ok_tod),
        .ok_salm (ok_salm),
        .ok_osc  (ok_osc),
        .ok_ctrl (ok_ctrl)
    );

    rtc_time_count #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .ld_sec   (ok_sec),
        .ld_sub   (ok_sub),
        .wdata    (bus_wdata),
        .sec      (sec),
        .sub      (sub),
        .sec_step (sec_step),
        .sec_nxt  (sec_nxt)
    );

    rtc_sub_alarm #(.SUB_W(SUB_W)) u_subalm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .en     (q.sub_en),
        .reload (q.salm),
        .hit    (sub_hit)
    );

    always_comb begin
        d       = q;
        clr     = (wr_req && bus_addr == A_FLAG) ? bus_wdata[1:0] : 2'b00;
        tod_set = q.tod_en && sec_step && (sec_nxt[TOD_W-1:0] == q.tod);
        if (ok_tod)  d.tod  = bus_wdata[TOD_W-1:0];
        if (ok_salm) d.salm = bus_wdata[SUB_W-1:0];
        if (ok_osc)  d.osc  = bus_wdata[OSC_W-1:0];
        if (ok_ctrl) begin
            d.wen    = bus_wdata[CB_WEN];
            d.tod_en = bus_wdata[CB_TOD_EN];
            d.sub_en = bus_wdata[CB_SUB_EN];
        end
        d.tod_flag = (q.tod_flag && !clr[FB_TOD]) || tod_set;
        d.sub_flag = (q.sub_flag && !clr[FB_SUB]) || sub_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_SEC:  bus_rdata = sec;
            A_SUB:  bus_rdata[SUB_W-1:0] = sub;
            A_TOD:  bus_rdata[TOD_W-1:0] = q.tod;
            A_SALM: bus_rdata[SUB_W-1:0] = q.salm;
            A_OSC:  bus_rdata[OSC_W-1:0] = q.osc;
            A_CTRL: begin
                bus_rdata[CB_BUSY]   = busy;
                bus_rdata[CB_READY]  = ready;
                bus_rdata[CB_WEN]    = q.wen;
                bus_rdata[CB_TOD_EN] = q.tod_en;
                bus_rdata[CB_SUB_EN] = q.sub_en;
            end
            A_FLAG: begin
                bus_rdata[FB_TOD] = q.tod_flag;
                bus_rdata[FB_SUB] = q.sub_flag;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign rd_stale  = bus_sel && !bus_wr && tick_en &&
                       (bus_addr == A_SEC || bus_addr == A_SUB);
    assign tod_alarm = q.tod_flag;
    assign sub_alarm = q.sub_flag;

    AST_TOD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && bus_addr == A_TOD && (busy || q.tod_en)) |=> $stable(q.tod)); // R5

    AST_SALM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && bus_addr == A_SALM && (busy || q.sub_en)) |=> $stable(q.salm)); // R6

    AST_OSC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && bus_addr == A_OSC && (busy || !q.wen)) |=> $stable(q.osc)); // R4

    AST_CTRL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && bus_addr == A_CTRL && busy)
        |=> $stable(q.wen) && $stable(q.tod_en) && $stable(q.sub_en)); // R3

    AST_TOD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_alarm && !(wr_req && bus_addr == A_FLAG && bus_wdata[FB_TOD])) |=> tod_alarm); // R8

    AST_SUB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_alarm && !(wr_req && bus_addr == A_FLAG && bus_wdata[FB_SUB])) |=> sub_alarm); // R9

    AST_STALE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stale |-> !ready); // R2

endmodule

// File: tb/sim_rtc_guarded.sv
module sim_rtc_guarded;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        rd_stale;
    logic        tod_alarm;
    logic        sub_alarm;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rtc_guarded u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rd_stale  (rd_stale),
        .tod_alarm (tod_alarm),
        .sub_alarm (sub_alarm)
    );

    // Behavioural reference state
    longint m_sec = 0;
    int     m_sub = 0, m_tod = 0, m_sa = 0, m_osc = 0, m_ssc = 0, m_busy = 0;
    bit     m_wen = 0, m_ten = 0, m_sen = 0, m_tf = 0, m_sf = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_sub = 0; m_tod = 0; m_sa = 0; m_osc = 0; m_ssc = 0;
            m_busy = 0; m_wen = 0; m_ten = 0; m_sen = 0; m_tf = 0; m_sf = 0;
        end else begin
            bit w, a_sec, a_sub, a_tod, a_sa, a_osc, a_ct, any, tset, sset;
            int wd;
            int clrv;
            wd    = int'(bus_wdata);
            w     = bus_sel && bus_wr && (m_busy == 0);
            a_sec = w && bus_addr == 0 && m_wen;
            a_sub = w && bus_addr == 1 && m_wen;
            a_tod = w && bus_addr == 2 && !m_ten;
            a_sa  = w && bus_addr == 3 && !m_sen;
            a_osc = w && bus_addr == 4 && m_wen;
            a_ct  = w && bus_addr == 5;
            any   = a_sec || a_sub || a_tod || a_sa || a_osc || a_ct;
            clrv  = (bus_sel && bus_wr && bus_addr == 6) ? (wd & 3) : 0;
            sset = 0;
            if (!m_sen) m_ssc = m_sa;
            else if (tick_en) begin
                if (m_ssc <= 1) begin sset = 1; m_ssc = m_sa; end
                else m_ssc = m_ssc - 1;
            end
            tset = 0;
            if (a_sec) m_sec = longint'(bus_wdata);
            if (a_sub) m_sub = wd & 4095;
            if (tick_en && !a_sec && !a_sub) begin
                m_sub = m_sub + 1;
                if (m_sub == 4096) begin
                    m_sub = 0;
                    m_sec = (m_sec + 1) & 64'hFFFF_FFFF;
                    if (m_ten && ((m_sec & 64'hFFFFF) == longint'(m_tod))) tset = 1;
                end
            end
            m_tf = (m_tf && !clrv[0]) || tset;
            m_sf = (m_sf && !clrv[1]) || sset;
            if (any) m_busy = 2;
            else if (m_busy > 0) m_busy = m_busy - 1;
            if (a_tod) m_tod = wd & 32'hFFFFF;
            if (a_sa)  m_sa  = wd & 4095;
            if (a_osc) m_osc = wd & 255;
            if (a_ct) begin m_wen = bus_wdata[2]; m_ten = bus_wdata[3]; m_sen = bus_wdata[4]; end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_sec[31:0];
            3'd1: return 32'(m_sub);
            3'd2: return 32'(m_tod);
            3'd3: return 32'(m_sa);
            3'd4: return 32'(m_osc);
            3'd5: return {27'd0, m_sen, m_ten, m_wen, !tick_en, m_busy != 0};
            3'd6: return {30'd0, m_sf, m_tf};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0, 3'd1: return "R1";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R4";
            3'd5: return "R3";
            3'd6: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
            chk("R2", 32'(rd_stale), 32'(bus_sel && !bus_wr && tick_en && bus_addr <= 3'd1));
            chk("R8", 32'(tod_alarm), 32'(m_tf));
            chk("R9", 32'(sub_alarm), 32'(m_sf));
        end
    end

    task automatic wr_op(input logic [2:0] a, input logic [31:0] dv);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = dv;
        @(negedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
        @(negedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1; tick_en = 1;
            @(negedge clk); #1; tick_en = 0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        rd_chk(3'd0, 32'd0, "R11");
        rd_chk(3'd5, 32'h2, "R11");
        rd_chk(3'd6, 32'd0, "R11");
        rd_chk(3'd7, 32'd0, "R11");
        // R4 counter write without permission
        wr_op(3'd0, 32'd55); idle(3);
        rd_chk(3'd0, 32'd0, "R4");
        // R7 control load
        wr_op(3'd5, 32'h4); idle(3);
        rd_chk(3'd5, 32'h6, "R7");
        // R1 wrap
        wr_op(3'd0, 32'd6); idle(3);
        wr_op(3'd1, 32'd4094); idle(3);
        ticks(1);
        rd_chk(3'd1, 32'd4095, "R1");
        ticks(1);
        rd_chk(3'd1, 32'd0, "R1");
        rd_chk(3'd0, 32'd7, "R1");
        // R3 busy window drops second write
        wr_op(3'd4, 32'hAA);
        wr_op(3'd4, 32'h55); idle(3);
        rd_chk(3'd4, 32'hAA, "R3");
        wr_op(3'd5, 32'h4);
        rd_chk(3'd5, 32'h7, "R3");
        idle(3);
        rd_chk(3'd5, 32'h6, "R3");
        // R5 time-of-day alarm locked while enabled
        wr_op(3'd2, 32'd9); idle(3);
        wr_op(3'd5, 32'hC); idle(3);
        wr_op(3'd2, 32'd3); idle(3);
        rd_chk(3'd2, 32'd9, "R5");
        // R8 flag set on step into match
        wr_op(3'd1, 32'd4095); idle(3);
        ticks(1);
        chk("R8", 32'(tod_alarm), 32'd0);
        wr_op(3'd1, 32'd4095); idle(3);
        ticks(1);
        chk("R8", 32'(tod_alarm), 32'd1);
        ticks(3);
        chk("R8", 32'(tod_alarm), 32'd1);
        wr_op(3'd6, 32'd1); idle(1);
        chk("R8", 32'(tod_alarm), 32'd0);
        // R6 sub-second reload locked while enabled
        wr_op(3'd3, 32'd3); idle(3);
        wr_op(3'd5, 32'h14); idle(3);
        wr_op(3'd3, 32'd7); idle(3);
        rd_chk(3'd3, 32'd3, "R6");
        // R9 fires every third tick
        ticks(2);
        chk("R9", 32'(sub_alarm), 32'd0);
        ticks(1);
        chk("R9", 32'(sub_alarm), 32'd1);
        wr_op(3'd6, 32'd2); idle(3);
        chk("R9", 32'(sub_alarm), 32'd0);
        ticks(2);
        chk("R9", 32'(sub_alarm), 32'd0);
        ticks(1);
        chk("R9", 32'(sub_alarm), 32'd1);
        // R2 read coinciding with a tick
        @(negedge clk); #1;
        tick_en = 1; bus_sel = 1; bus_wr = 0; bus_addr = 3'd0;
        #2; chk("R2", 32'(rd_stale), 32'd1);
        bus_addr = 3'd5;
        #1; chk("R2", 32'(bus_rdata[1]), 32'd0);
        @(negedge clk); #1;
        tick_en = 0; bus_sel = 0;
        #2; chk("R2", 32'(rd_stale), 32'd0);
        // R10 counter write in a tick cycle
        @(negedge clk); #1;
        tick_en = 1; bus_sel = 1; bus_wr = 1; bus_addr = 3'd1; bus_wdata = 32'd100;
        @(negedge clk); #1;
        tick_en = 0; bus_sel = 0; bus_wr = 0;
        idle(3);
        rd_chk(3'd1, 32'd100, "R10");
        ticks(1);
        rd_chk(3'd1, 32'd101, "R10");
        // R4 trim write refused after permission withdrawn
        wr_op(3'd5, 32'h0); idle(3);
        wr_op(3'd4, 32'h33); idle(3);
        rd_chk(3'd4, 32'hAA, "R4");
        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule